// File: doc/BRIEF.md
# Circular Acquisition Sequencer

This block paces a ring-buffer acquisition around a trigger event. It enables sampling as soon as an acquisition begins and moves a circular write address forward on every sample tick, so that new samples replace the oldest ones. Trigger recognition stays off until a programmed number of pre-trigger samples has been collected. While the trigger is armed, sampling carries on until a trigger arrives. The block then takes just enough post-trigger samples to complete the record and stops.

The surrounding buffer writes a sample at `wr_addr` whenever `sample_tick` and `samp_en` are both high. When `acq_done` is raised, the stored record can be read out, starting at `trig_addr` and wrapping at the record length. A pulse on `readout_done` starts the next acquisition with freshly loaded settings. The record length must be at least 1. A pre-trigger count greater than the record length is clamped to the record length.

Top module: `acq_sequencer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `samp_en`, `trig_arm` and `acq_done` are 0 and `wr_addr` is 0. In the next cycle `samp_en` becomes 1.
- R2: `pre_len` and `rec_len` are sampled only in the cycle an acquisition starts, and `pre_len` is clamped to `rec_len`. Changing either input during an acquisition has no effect on it.
- R3: During the pre-trigger fill, `samp_en`=1 and `trig_arm`=0. `trig_arm` rises in the cycle after the `pre_len`-th accepted sample tick. With `pre_len`=0, `trig_arm` rises together with `samp_en` at the start.
- R4: A trigger that arrives while the block is not armed is discarded, not stored. This includes a trigger in the same cycle as the tick that completes the fill. `trig_arm` stays 1 afterwards until a new trigger arrives.
- R5: Each sample tick with `samp_en`=1 advances `wr_addr` by one, and `wr_addr` returns from `rec_len`-1 to 0. A tick with `samp_en`=0 leaves `wr_addr` unchanged.
- R6: A trigger while `trig_arm`=1 clears `trig_arm` in the next cycle and saves `trig_addr`. The saved value is the current `wr_addr` if there is no tick in that cycle, or the following slot if a tick coincides with the trigger. In the coincident case the sample taken in that cycle belongs to the pre-trigger part.
- R7: After the trigger, exactly `rec_len` − `pre_len` further ticks are accepted. In the cycle after the last one, `samp_en` falls to 0 and `acq_done` rises to 1. When `pre_len` equals `rec_len`, this happens in the cycle right after the trigger.
- R8: `acq_done` stays 1 until `readout_done` is pulsed. The block then spends one cycle with all outputs low and starts again: `samp_en`=1, `wr_addr`=0, and the new settings in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One pulse per incoming sample |
| trig_in | input | 1 | Trigger event |
| pre_len | input | ADDR_W+1 | Number of pre-trigger samples |
| rec_len | input | ADDR_W+1 | Record length in samples (1 to 2^ADDR_W) |
| readout_done | input | 1 | Pulse when the record has been read out |
| samp_en | output | 1 | Buffer write enable for ticks |
| trig_arm | output | 1 | Trigger recognition is enabled |
| wr_addr | output | ADDR_W | Circular write address |
| acq_done | output | 1 | Record complete, sampling stopped |
| trig_addr | output | ADDR_W | Write address saved at the trigger |

## Verification
Two functions can fall in the same cycle: accepting a sample tick and recognising a trigger. The bench provokes this in two ways. It raises the trigger together with a tick while the block is armed, and expects the saved address to be the slot after the current one and the write address to advance. It also raises the trigger together with the tick that completes the pre-trigger fill, and expects the trigger to be lost, so that the block is still armed and sampling afterwards.

// File: rtl/acq_pkg.sv
package acq_pkg;
  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_FILL  = 3'd1,
    S_ARMED = 3'd2,
    S_POST  = 3'd3,
    S_DONE  = 3'd4
  } acq_state_t;
endpackage

// File: rtl/acq_wrap_ptr.sv
module acq_wrap_ptr #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              adv,
  input  logic [ADDR_W-1:0] last,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_nxt
);
  always_comb begin
    if (ptr == last) ptr_nxt = '0;
    else             ptr_nxt = ptr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) ptr <= '0;
    else if (adv)   ptr <= ptr_nxt;
  end

  // R5: without a tick the address must not move
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (rst)
    (!adv && !clr) |=> $stable(ptr));
endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import acq_pkg::*;
#(
  parameter int ADDR_W = 6,
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_tick,
  input  logic              trig_in,
  input  logic              readout_done,
  input  logic [LEN_W-1:0]  pre_len,
  input  logic [LEN_W-1:0]  rec_len,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] ptr_nxt,
  output logic              ptr_clr,
  output logic              ptr_adv,
  output logic [LEN_W-1:0]  cfg_rec,
  output logic              samp_en,
  output logic              trig_arm,
  output logic              acq_done,
  output logic [ADDR_W-1:0] trig_addr
);
  acq_state_t       state, state_d;
  logic [LEN_W-1:0] cfg_pre, cnt, cnt_inc, cfg_post, pre_clamped;
  logic             trig_hit;

  assign cnt_inc     = cnt + 1'b1;
  assign cfg_post    = cfg_rec - cfg_pre;
  assign pre_clamped = (pre_len > rec_len) ? rec_len : pre_len;
  assign ptr_clr     = (state == S_IDLE);
  assign ptr_adv     = sample_tick && samp_en;
  assign trig_hit    = (state == S_ARMED) && trig_in;

  always_comb begin
    state_d = state;
    unique case (state)
      S_IDLE:  state_d = (pre_clamped == '0) ? S_ARMED : S_FILL;
      S_FILL:  if (sample_tick && cnt_inc == cfg_pre) state_d = S_ARMED;
      S_ARMED: if (trig_in) state_d = (cfg_post == '0) ? S_DONE : S_POST;
      S_POST:  if (sample_tick && cnt_inc == cfg_post) state_d = S_DONE;
      S_DONE:  if (readout_done) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      samp_en   <= 1'b0;
      trig_arm  <= 1'b0;
      acq_done  <= 1'b0;
      cnt       <= '0;
      cfg_pre   <= '0;
      cfg_rec   <= LEN_W'(1);
      trig_addr <= '0;
    end else begin
      state    <= state_d;
      samp_en  <= (state_d == S_FILL) || (state_d == S_ARMED) || (state_d == S_POST);
      trig_arm <= (state_d == S_ARMED);
      acq_done <= (state_d == S_DONE);
      if (state == S_IDLE) begin
        cfg_pre <= pre_clamped;
        cfg_rec <= rec_len;
        cnt     <= '0;
      end else if (trig_hit) begin
        cnt       <= '0;
        trig_addr <= sample_tick ? ptr_nxt : ptr;
      end else if (sample_tick && (state == S_FILL || state == S_POST)) begin
        cnt <= (state_d != state) ? '0 : cnt_inc;
      end
    end
  end

  // R4: a fill phase never leads straight into post-trigger sampling
  a_r4_fill_no_post: assert property (@(posedge clk) disable iff (rst)
    (state == S_FILL) |=> (state == S_FILL || state == S_ARMED));
  // R6: saved trigger address is frozen during post-trigger sampling
  a_r6_addr_frozen: assert property (@(posedge clk) disable iff (rst)
    (state == S_POST) |=> $stable(trig_addr));
  // R7: sampling is stopped once the record is complete
  a_r7_done_stops: assert property (@(posedge clk) disable iff (rst)
    acq_done |-> !samp_en && !trig_arm);
  // R8: completion holds until readout is acknowledged
  a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
    (acq_done && !readout_done) |=> acq_done);
  // R3: at most one phase flag active
  a_r3_flags_excl: assert property (@(posedge clk) disable iff (rst)
    $onehot0({trig_arm, acq_done}));
endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer #(
  parameter int ADDR_W = 6,
  localparam int LEN_W = ADDR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_tick,
  input  logic              trig_in,
  input  logic [LEN_W-1:0]  pre_len,
  input  logic [LEN_W-1:0]  rec_len,
  input  logic              readout_done,
  output logic              samp_en,
  output logic              trig_arm,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              acq_done,
  output logic [ADDR_W-1:0] trig_addr
);
  logic              ptr_clr, ptr_adv;
  logic [LEN_W-1:0]  cfg_rec, last_w;
  logic [ADDR_W-1:0] ptr_nxt;

  assign last_w = cfg_rec - 1'b1;

  acq_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .trig_in(trig_in),
    .readout_done(readout_done), .pre_len(pre_len), .rec_len(rec_len),
    .ptr(wr_addr), .ptr_nxt(ptr_nxt), .ptr_clr(ptr_clr), .ptr_adv(ptr_adv),
    .cfg_rec(cfg_rec), .samp_en(samp_en), .trig_arm(trig_arm),
    .acq_done(acq_done), .trig_addr(trig_addr)
  );

  acq_wrap_ptr #(.ADDR_W(ADDR_W)) u_ptr (
    .clk(clk), .rst(rst), .clr(ptr_clr), .adv(ptr_adv),
    .last(last_w[ADDR_W-1:0]), .ptr(wr_addr), .ptr_nxt(ptr_nxt)
  );

  // R5: write address always inside the record
  a_r5_in_range: assert property (@(posedge clk) disable iff (rst)
    !ptr_clr |-> ({1'b0, wr_addr} < cfg_rec));
endmodule

// File: tb/tb_acq_sequencer.sv
module tb_acq_sequencer;
  localparam int ADDR_W = 6;
  localparam int LEN_W  = ADDR_W + 1;

  logic clk = 1'b0;
  logic rst, sample_tick, trig_in, readout_done;
  logic [LEN_W-1:0] pre_len, rec_len;
  logic samp_en, trig_arm, acq_done;
  logic [ADDR_W-1:0] wr_addr, trig_addr;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  acq_sequencer #(.ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .sample_tick(sample_tick), .trig_in(trig_in),
    .pre_len(pre_len), .rec_len(rec_len), .readout_done(readout_done),
    .samp_en(samp_en), .trig_arm(trig_arm), .wr_addr(wr_addr),
    .acq_done(acq_done), .trig_addr(trig_addr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      sample_tick = 1'b1;
      @(negedge clk);
    end
    sample_tick = 1'b0;
  endtask

  task automatic trig(input bit with_tick);
    trig_in = 1'b1; sample_tick = with_tick;
    @(negedge clk);
    trig_in = 1'b0; sample_tick = 1'b0;
  endtask

  task automatic readout();
    readout_done = 1'b1;
    @(negedge clk);
    readout_done = 1'b0;
    chk("R8 idle samp_en", samp_en, 0);
    chk("R8 idle acq_done", acq_done, 0);
    @(negedge clk);
    chk("R8 restart samp_en", samp_en, 1);
    chk("R8 restart wr_addr", wr_addr, 0);
  endtask

  task automatic t_reset();
    rst = 1; sample_tick = 0; trig_in = 0; readout_done = 0;
    pre_len = 3; rec_len = 8;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R1 samp_en", samp_en, 0);
    chk("R1 trig_arm", trig_arm, 0);
    chk("R1 acq_done", acq_done, 0);
    chk("R1 wr_addr", wr_addr, 0);
    @(negedge clk);
    chk("R1 start samp_en", samp_en, 1);
  endtask

  task automatic t_basic();
    pre_len = 1; rec_len = 4;          // R2: ignored mid-acquisition
    ticks(2);
    chk("R3 not armed", trig_arm, 0);
    chk("R5 wr_addr", wr_addr, 2);
    trig(0);
    chk("R4 fill trig ignored", trig_arm, 0);
    chk("R4 still sampling", samp_en, 1);
    ticks(1);
    chk("R3 armed", trig_arm, 1);
    chk("R2 pre kept", wr_addr, 3);
    repeat (2) @(negedge clk);
    chk("R4 not latched", trig_arm, 1);
    ticks(7);
    chk("R2 R5 wrap at kept len", wr_addr, 2);
    trig(0);
    chk("R6 arm cleared", trig_arm, 0);
    chk("R6 trig_addr", trig_addr, 2);
    ticks(4);
    chk("R7 not yet done", acq_done, 0);
    chk("R7 wr_addr", wr_addr, 6);
    ticks(1);
    chk("R7 done", acq_done, 1);
    chk("R7 samp_en off", samp_en, 0);
    ticks(2);
    chk("R5 tick while stopped", wr_addr, 7);
    repeat (3) @(negedge clk);
    chk("R8 done held", acq_done, 1);
    pre_len = 0; rec_len = 4;
    readout();
  endtask

  task automatic t_zero_pre();
    chk("R3 pre zero armed", trig_arm, 1);
    trig(1);
    chk("R6 coincident trig_addr", trig_addr, 1);
    chk("R6 coincident wr_addr", wr_addr, 1);
    ticks(3);
    chk("R7 post count", acq_done, 0);
    chk("R5 wrap len4", wr_addr, 0);
    ticks(1);
    chk("R7 done len4", acq_done, 1);
    pre_len = 5; rec_len = 5;
    readout();
  endtask

  task automatic t_full_pre();
    ticks(4);
    trig_in = 1'b1;
    ticks(1);                          // trigger on the completing tick
    trig_in = 1'b0;
    chk("R4 coincident fill trig", trig_arm, 1);
    chk("R4 no done", acq_done, 0);
    chk("R5 wrap len5", wr_addr, 0);
    trig(0);
    chk("R7 immediate done", acq_done, 1);
    chk("R6 trig_addr full", trig_addr, 0);
    pre_len = 9; rec_len = 6;
    readout();
  endtask

  task automatic t_clamp();
    ticks(5);
    chk("R2 clamp not armed", trig_arm, 0);
    ticks(1);
    chk("R2 clamp armed", trig_arm, 1);
    trig(0);
    chk("R2 clamp done", acq_done, 1);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_zero_pre();
    t_full_pre();
    t_clamp();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule